// File: doc/BRIEF.md
# Receive Descriptor Ring Scatter Engine

This block takes a received frame as a byte stream (valid, last, ready), where the stream already carries the four trailing check-sequence bytes. It scatters the frame into buffers named by descriptors that sit in a ring in system memory, and it reaches that memory through a 32-bit request/acknowledge master port. Each descriptor is two big-endian words. Word 0 holds a 16-bit flag field in bits 31:16 and a 16-bit length in bits 15:0. Word 1 holds the buffer pointer.

Software fills the ring and marks each descriptor empty. It then writes the receive-demand register. The engine reads the current descriptor and arms only if that descriptor is empty. Each frame is cut into chunks no larger than the programmed buffer size. Every descriptor used is written back with its byte count and updated flags, and a pulse reports the end of each buffer or frame. After each frame the engine checks the next descriptor again to decide whether it stays armed. Frames above a fixed cap are truncated. Frames above a programmable limit are flagged.

Top module: `rxr_ring_engine`

## Requirements
- R1: A write to the demand register (offset 0x010) while `ctrl_en` is high and the receiver is disarmed reads descriptor word 0 at the current pointer. The receiver arms only if flag bit 15 (empty) is set. A demand write while `ctrl_en` is low has no effect. Bit 24 of a demand-register read returns the armed state, also driven on `rx_armed`.
- R2: While disarmed, `in_ready` stays low and no stream byte is accepted.
- R3: Driving `ctrl_en` low disarms the receiver on the next cycle.
- R4: A buffer holds at most the programmed buffer size. That size is set at offset 0x188, writes are masked with 0x7F0, the reset value is 0x600, and a stored zero acts as 16. Byte k of a buffer is written to byte lane 31-8*(k mod 4) of the word at pointer+4*(k div 4). The low two bits of the pointer are ignored, and every memory access is word aligned.
- R5: Each used descriptor gets word 0 written back. Bits 15:0 carry the bytes stored in that buffer. Bits 31:16 carry the original flags with bit 15 cleared. The final buffer of a frame also gets bit 11 (last).
- R6: The end of a frame's final buffer gives a one-cycle `ev_frame` pulse. Every other buffer gives a one-cycle `ev_buffer` pulse. The pulse comes one cycle after the write-back is acknowledged, and the two pulses never occur together.
- R7: After a write-back, the next descriptor is the ring start if flag bit 13 (wrap) was set, and the current address plus 8 otherwise. The ring start is at offset 0x180 with its low two bits forced to zero. Writing it also loads the current pointer.
- R8: Only the first 2032 bytes of a frame are stored, and later bytes are consumed and discarded. A frame that exceeds 2032 bytes gets bit 0 (truncated) and bit 5 (length error) on its final descriptor.
- R9: The receive control register is at offset 0x084. It resets to 0x05EE0001 and stores writes masked with 0x07FF003F. A frame whose total length exceeds bits 31:16 of this register gets bit 5 on its final descriptor.
- R10: After each frame, descriptor word 0 at the new pointer is read. The receiver stays armed if bit 15 is set and disarms otherwise.
- R11: If the next descriptor is not empty partway through a frame, the rest of the frame is accepted and dropped. That descriptor is left untouched, `rx_overrun` is set and stays set until reset, and the receiver then disarms.
- R12: Each memory request holds its address and data until it is acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctrl_en | input | 1 | Controller enable; low disarms |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 10 | Register byte offset |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data for `cfg_addr` |
| in_valid | input | 1 | Stream byte valid |
| in_data | input | 8 | Stream byte |
| in_last | input | 1 | Final byte of frame |
| in_ready | output | 1 | Engine accepts the byte |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 32 | Word-aligned byte address |
| mem_wdata | output | 32 | Write data, big-endian lanes |
| mem_be | output | 4 | Byte enables, bit 3 = bits 31:24 |
| mem_rdata | input | 32 | Read data, valid with ack |
| mem_ack | input | 1 | Request completes |
| ev_frame | output | 1 | Frame-complete pulse |
| ev_buffer | output | 1 | Buffer-complete pulse |
| rx_armed | output | 1 | Receiver armed |
| rx_overrun | output | 1 | Sticky mid-frame ring exhaustion |

## Verification
A wrong pointer or a lost wrap shows up at the first write-back after the fault, because the descriptor address in the scoreboard stops matching. A wrong byte count or wrong status flags show up in the same write-back word. A bad armed state appears within a few cycles of a demand write or of a frame's end, through `in_ready`, through `rx_armed` and through bit 24 of the demand register. A wrong lane or a wrong buffer offset stays hidden until the buffer contents are compared after the frame.

// File: rtl/rxr_pkg.sv
package rxr_pkg;

    // descriptor flag bit positions
    localparam int BD_EMPTY = 15;
    localparam int BD_WRAP  = 13;
    localparam int BD_LAST  = 11;
    localparam int BD_LONG  = 5;
    localparam int BD_TRUNC = 0;

    // register offsets
    localparam logic [9:0] OFS_DEMAND = 10'h010;
    localparam logic [9:0] OFS_CTRL   = 10'h084;
    localparam logic [9:0] OFS_RING   = 10'h180;
    localparam logic [9:0] OFS_MAXBUF = 10'h188;

    localparam logic [31:0] CTRL_RST   = 32'h05EE_0001;
    localparam logic [31:0] CTRL_MASK  = 32'h07FF_003F;
    localparam logic [10:0] MAXBUF_MSK = 11'h7F0;
    localparam logic [10:0] MAXBUF_RST = 11'h600;
    localparam logic [10:0] MAXBUF_MIN = 11'd16;

    typedef enum logic [3:0] {
        ST_OFF,   // disarmed
        ST_RDF,   // read descriptor word 0
        ST_RDP,   // read buffer pointer
        ST_FILL,  // accept bytes into buffer
        ST_WRD,   // write packed data word
        ST_PEEK,  // buffer full, wait for evidence of more bytes
        ST_DISC,  // past the cap, discard to end of frame
        ST_WBD,   // write descriptor back
        ST_DROP   // ring exhausted mid-frame, drop to end
    } rxr_state_e;

    typedef struct packed {
        logic [15:0] flags;
        logic [15:0] len;
    } bd_head_t;

    function automatic logic [15:0] bd_close(input logic [15:0] f,
                                             input logic fin,
                                             input logic tr,
                                             input logic lg);
        logic [15:0] r;
        r = f;
        r[BD_EMPTY] = 1'b0;
        if (fin) begin
            r[BD_LAST] = 1'b1;
            if (tr) r[BD_TRUNC] = 1'b1;
            if (lg) r[BD_LONG]  = 1'b1;
        end
        return r;
    endfunction

endpackage

// File: rtl/rxr_cfg.sv
module rxr_cfg
    import rxr_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        we,
    input  logic [9:0]  addr,
    input  logic [31:0] wdata,
    input  logic        armed,
    output logic [31:0] rdata,
    output logic [31:0] ring_base,
    output logic [10:0] maxb,
    output logic [15:0] limit,
    output logic        demand_pulse,
    output logic        ring_load,
    output logic [31:0] ring_val
);
    logic [31:0] ctrl_q;
    logic [31:0] ring_q;
    logic [10:0] maxbuf_q;

    assign ring_val     = {wdata[31:2], 2'b00};
    assign demand_pulse = we && (addr == OFS_DEMAND);
    assign ring_load    = we && (addr == OFS_RING);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q   <= CTRL_RST;
            ring_q   <= '0;
            maxbuf_q <= MAXBUF_RST;
        end else if (we) begin
            case (addr)
                OFS_CTRL:   ctrl_q   <= wdata & CTRL_MASK;
                OFS_RING:   ring_q   <= ring_val;
                OFS_MAXBUF: maxbuf_q <= wdata[10:0] & MAXBUF_MSK;
                default: ;
            endcase
        end
    end

    assign ring_base = ring_q;
    assign limit     = ctrl_q[31:16];
    assign maxb      = (maxbuf_q == '0) ? MAXBUF_MIN : maxbuf_q;

    always_comb begin
        case (addr)
            OFS_DEMAND: rdata = {7'd0, armed, 24'd0};
            OFS_CTRL:   rdata = ctrl_q;
            OFS_RING:   rdata = ring_q;
            OFS_MAXBUF: rdata = {21'd0, maxbuf_q};
            default:    rdata = '0;
        endcase
    end
endmodule

// File: rtl/rxr_pack.sv
module rxr_pack (
    input  logic        clk,
    input  logic        rst,
    input  logic        clear,
    input  logic        push,
    input  logic [7:0]  din,
    output logic [31:0] word,
    output logic [3:0]  be,
    output logic [1:0]  lane
);
    always_ff @(posedge clk) begin
        if (rst || clear) begin
            word <= '0;
            be   <= '0;
            lane <= '0;
        end else if (push) begin
            for (int k = 0; k < 4; k++) begin
                if (lane == 2'(k)) begin
                    word[31-8*k -: 8] <= din;
                    be[3-k]           <= 1'b1;
                end
            end
            lane <= lane + 2'd1;
        end
    end
endmodule

// File: rtl/rxr_ctrl.sv
module rxr_ctrl
    import rxr_pkg::*;
#(
    parameter int FRAME_CAP = 2032,
    parameter int CNT_W     = 16
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        ctrl_en,
    input  logic        demand_pulse,
    input  logic        ring_load,
    input  logic [31:0] ring_val,
    input  logic [31:0] ring_base,
    input  logic [10:0] maxb,
    input  logic [15:0] limit,
    input  logic        in_valid,
    input  logic        in_last,
    output logic        in_ready,
    output logic        pack_push,
    output logic        pack_clear,
    input  logic [1:0]  pack_lane,
    input  logic [31:0] pack_word,
    input  logic [3:0]  pack_be,
    output logic        mem_req,
    output logic        mem_we,
    output logic [31:0] mem_addr,
    output logic [31:0] mem_wdata,
    output logic [3:0]  mem_be,
    input  logic [31:0] mem_rdata,
    input  logic        mem_ack,
    output logic        ev_frame,
    output logic        ev_buffer,
    output logic        armed,
    output logic        overrun
);
    localparam int CAP_W = $clog2(FRAME_CAP + 1);
    localparam logic [CAP_W-1:0] CAP_V = CAP_W'(FRAME_CAP);

    rxr_state_e        state;
    logic [31:0]       cur_ptr;
    logic [31:0]       data_addr;
    logic [15:0]       desc_flags;
    logic [10:0]       buf_cnt;
    logic [CAP_W-1:0]  stored;
    logic [CNT_W-1:0]  frm_cnt;
    logic              last_seen;
    logic              trunc;
    logic              cont;

    logic [10:0]       buf_n;
    logic [CAP_W-1:0]  sto_n;
    logic [CNT_W-1:0]  frm_n;
    logic              long_frm;
    bd_head_t          head;

    assign buf_n    = buf_cnt + 11'd1;
    assign sto_n    = stored + 1'b1;
    assign frm_n    = (&frm_cnt) ? frm_cnt : frm_cnt + 1'b1;
    assign long_frm = trunc || (CNT_W'(limit) < frm_cnt);

    assign head.flags = bd_close(desc_flags, last_seen, trunc, long_frm);
    assign head.len   = 16'(buf_cnt);

    assign in_ready   = (state == ST_FILL) || (state == ST_DISC) || (state == ST_DROP);
    assign pack_push  = (state == ST_FILL) && in_valid;
    assign pack_clear = ((state == ST_WRD) && mem_ack) || (state == ST_OFF);

    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = cur_ptr;
        mem_wdata = head;
        mem_be    = 4'hF;
        case (state)
            ST_RDF: mem_req = 1'b1;
            ST_RDP: begin mem_req = 1'b1; mem_addr = cur_ptr + 32'd4; end
            ST_WRD: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = data_addr;
                mem_wdata = pack_word;
                mem_be    = pack_be;
            end
            ST_WBD: begin mem_req = 1'b1; mem_we = 1'b1; end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= ST_OFF;
            cur_ptr    <= '0;
            data_addr  <= '0;
            desc_flags <= '0;
            buf_cnt    <= '0;
            stored     <= '0;
            frm_cnt    <= '0;
            last_seen  <= 1'b0;
            trunc      <= 1'b0;
            cont       <= 1'b0;
            armed      <= 1'b0;
            overrun    <= 1'b0;
            ev_frame   <= 1'b0;
            ev_buffer  <= 1'b0;
        end else begin
            ev_frame  <= 1'b0;
            ev_buffer <= 1'b0;
            if (!ctrl_en) begin
                state     <= ST_OFF;
                armed     <= 1'b0;
                buf_cnt   <= '0;
                stored    <= '0;
                frm_cnt   <= '0;
                last_seen <= 1'b0;
                trunc     <= 1'b0;
            end else begin
                case (state)
                    ST_OFF: if (demand_pulse && !armed) begin
                        cont  <= 1'b0;
                        state <= ST_RDF;
                    end
                    ST_RDF: if (mem_ack) begin
                        desc_flags <= mem_rdata[31:16];
                        if (mem_rdata[16 + BD_EMPTY]) begin
                            state <= ST_RDP;
                        end else if (cont) begin
                            overrun <= 1'b1;
                            state   <= ST_DROP;
                        end else begin
                            armed <= 1'b0;
                            state <= ST_OFF;
                        end
                    end
                    ST_RDP: if (mem_ack) begin
                        data_addr <= mem_rdata & ~32'h3;
                        armed     <= 1'b1;
                        state     <= ST_FILL;
                    end
                    ST_FILL: if (in_valid) begin
                        buf_cnt   <= buf_n;
                        stored    <= sto_n;
                        frm_cnt   <= frm_n;
                        last_seen <= in_last;
                        if (pack_lane == 2'd3 || buf_n >= maxb || sto_n == CAP_V || in_last)
                            state <= ST_WRD;
                    end
                    ST_WRD: if (mem_ack) begin
                        data_addr <= data_addr + 32'd4;
                        if (last_seen)           state <= ST_WBD;
                        else if (stored == CAP_V) state <= ST_DISC;
                        else if (buf_cnt >= maxb) state <= ST_PEEK;
                        else                      state <= ST_FILL;
                    end
                    ST_PEEK: if (in_valid) state <= ST_WBD;
                    ST_DISC: if (in_valid) begin
                        frm_cnt <= frm_n;
                        trunc   <= 1'b1;
                        if (in_last) begin
                            last_seen <= 1'b1;
                            state     <= ST_WBD;
                        end
                    end
                    ST_WBD: if (mem_ack) begin
                        ev_frame  <= last_seen;
                        ev_buffer <= !last_seen;
                        cur_ptr   <= desc_flags[BD_WRAP] ? ring_base : cur_ptr + 32'd8;
                        buf_cnt   <= '0;
                        cont      <= !last_seen;
                        if (last_seen) begin
                            stored    <= '0;
                            frm_cnt   <= '0;
                            trunc     <= 1'b0;
                            last_seen <= 1'b0;
                        end
                        state <= ST_RDF;
                    end
                    ST_DROP: if (in_valid && in_last) begin
                        cont      <= 1'b0;
                        stored    <= '0;
                        frm_cnt   <= '0;
                        trunc     <= 1'b0;
                        last_seen <= 1'b0;
                        state     <= ST_RDF;
                    end
                    default: state <= ST_OFF;
                endcase
            end
            if (ring_load) cur_ptr <= ring_val;
        end
    end
endmodule

// File: rtl/rxr_ring_engine.sv
module rxr_ring_engine
    import rxr_pkg::*;
#(
    parameter int FRAME_CAP = 2032,
    parameter int CNT_W     = 16
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        ctrl_en,
    input  logic        cfg_we,
    input  logic [9:0]  cfg_addr,
    input  logic [31:0] cfg_wdata,
    output logic [31:0] cfg_rdata,
    input  logic        in_valid,
    input  logic [7:0]  in_data,
    input  logic        in_last,
    output logic        in_ready,
    output logic        mem_req,
    output logic        mem_we,
    output logic [31:0] mem_addr,
    output logic [31:0] mem_wdata,
    output logic [3:0]  mem_be,
    input  logic [31:0] mem_rdata,
    input  logic        mem_ack,
    output logic        ev_frame,
    output logic        ev_buffer,
    output logic        rx_armed,
    output logic        rx_overrun
);
    logic [31:0] ring_base, ring_val, pack_word;
    logic [10:0] maxb;
    logic [15:0] limit;
    logic        demand_pulse, ring_load, pack_push, pack_clear;
    logic [3:0]  pack_be;
    logic [1:0]  pack_lane;

    rxr_cfg u_cfg (
        .clk(clk), .rst(rst), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
        .armed(rx_armed), .rdata(cfg_rdata), .ring_base(ring_base), .maxb(maxb),
        .limit(limit), .demand_pulse(demand_pulse), .ring_load(ring_load),
        .ring_val(ring_val)
    );

    rxr_pack u_pack (
        .clk(clk), .rst(rst), .clear(pack_clear), .push(pack_push), .din(in_data),
        .word(pack_word), .be(pack_be), .lane(pack_lane)
    );

    rxr_ctrl #(.FRAME_CAP(FRAME_CAP), .CNT_W(CNT_W)) u_ctrl (
        .clk(clk), .rst(rst), .ctrl_en(ctrl_en), .demand_pulse(demand_pulse),
        .ring_load(ring_load), .ring_val(ring_val), .ring_base(ring_base),
        .maxb(maxb), .limit(limit), .in_valid(in_valid), .in_last(in_last),
        .in_ready(in_ready), .pack_push(pack_push), .pack_clear(pack_clear),
        .pack_lane(pack_lane), .pack_word(pack_word), .pack_be(pack_be),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_be(mem_be), .mem_rdata(mem_rdata),
        .mem_ack(mem_ack), .ev_frame(ev_frame), .ev_buffer(ev_buffer),
        .armed(rx_armed), .overrun(rx_overrun)
    );
endmodule

// File: rtl/rxr_ring_engine_chk.sv
module rxr_ring_engine_chk (
    input logic        clk,
    input logic        rst,
    input logic        ctrl_en,
    input logic        in_ready,
    input logic        rx_armed,
    input logic        rx_overrun,
    input logic        ev_frame,
    input logic        ev_buffer,
    input logic        mem_req,
    input logic        mem_we,
    input logic [31:0] mem_addr,
    input logic        mem_ack
);
    assert_ready_needs_arm_R2: assert property (@(posedge clk) disable iff (rst)
        !rx_armed |-> !in_ready);

    assert_disable_disarms_R3: assert property (@(posedge clk) disable iff (rst)
        !ctrl_en |=> !rx_armed);

    assert_word_aligned_R4: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> (mem_addr[1:0] == 2'b00));

    assert_single_event_R6: assert property (@(posedge clk) disable iff (rst)
        ev_frame |-> !ev_buffer);

    assert_event_after_write_R6: assert property (@(posedge clk) disable iff (rst)
        (ev_frame || ev_buffer) |-> $past(mem_ack && mem_we));

    assert_overrun_sticky_R11: assert property (@(posedge clk) disable iff (rst)
        rx_overrun |=> rx_overrun);

    assert_req_held_R12: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ack && ctrl_en) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));
endmodule

bind rxr_ring_engine rxr_ring_engine_chk u_chk (
    .clk(clk), .rst(rst), .ctrl_en(ctrl_en), .in_ready(in_ready),
    .rx_armed(rx_armed), .rx_overrun(rx_overrun), .ev_frame(ev_frame),
    .ev_buffer(ev_buffer), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_ack(mem_ack)
);

// File: tb/sim_rxr_ring_engine.sv
module sim_rxr_ring_engine;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst, ctrl_en, cfg_we, in_valid, in_last;
    logic [9:0]  cfg_addr;
    logic [31:0] cfg_wdata, cfg_rdata;
    logic [7:0]  in_data;
    logic        in_ready, mem_req, mem_we, mem_ack, ev_frame, ev_buffer, rx_armed, rx_overrun;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;
    logic [3:0]  mem_be;

    logic [31:0] mem [0:1023];
    logic        ack_q;
    logic [63:0] exp_q [$];
    int n_chk = 0, n_err = 0, n_rxf = 0, n_rxb = 0, exp_f = 0, exp_b = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rxr_ring_engine u0 (
        .clk(clk), .rst(rst), .ctrl_en(ctrl_en), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .in_valid(in_valid),
        .in_data(in_data), .in_last(in_last), .in_ready(in_ready), .mem_req(mem_req),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_be(mem_be),
        .mem_rdata(mem_rdata), .mem_ack(mem_ack), .ev_frame(ev_frame),
        .ev_buffer(ev_buffer), .rx_armed(rx_armed), .rx_overrun(rx_overrun)
    );

    // memory model: one-cycle acknowledge
    assign mem_ack   = ack_q;
    assign mem_rdata = mem[mem_addr[11:2]];
    always @(posedge clk) begin
        if (rst) ack_q <= 1'b0;
        else     ack_q <= mem_req && !ack_q;
        if (mem_req && mem_we && ack_q)
            for (int k = 0; k < 4; k++)
                if (mem_be[k]) mem[mem_addr[11:2]][8*k +: 8] <= mem_wdata[8*k +: 8];
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    // scoreboard monitor on descriptor write-backs
    always @(negedge clk) begin
        if (ev_frame)  n_rxf++;
        if (ev_buffer) n_rxb++;
        if (!rst && mem_req && mem_we && ack_q && mem_addr < 32'h100) begin
            if (exp_q.size() == 0) chk("R5 unexpected write-back", mem_addr, 32'hFFFF_FFFF);
            else begin
                logic [63:0] e;
                e = exp_q.pop_front();
                chk("R7 write-back address", mem_addr, e[63:32]);
                chk("R5 write-back word", mem_wdata, e[31:0]);
            end
        end
    end

    task automatic expect_wb(input logic [31:0] a, input logic [15:0] f, input logic [15:0] l);
        exp_q.push_back({a, f, l});
    endtask

    task automatic cfg_write(input logic [9:0] a, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic cfg_read(input logic [9:0] a, output logic [31:0] d);
        cfg_addr = a;
        #1 d = cfg_rdata;
    endtask

    task automatic setup_ring();
        for (int i = 0; i < 4; i++) begin
            mem[2*i]   = (i == 3) ? 32'hA000_0000 : 32'h8000_0000;
            mem[2*i+1] = 32'h400 + 32'(i) * 32'h100;
        end
    endtask

    task automatic send_byte(input logic [7:0] b, input bit l);
        logic ok;
        in_valid = 1'b1; in_data = b; in_last = l;
        forever begin
            ok = in_ready;
            @(negedge clk);
            if (ok) break;
        end
        in_valid = 1'b0; in_last = 1'b0;
    endtask

    task automatic send_frame(input int n, input logic [7:0] seed);
        @(negedge clk);
        for (int i = 0; i < n; i++) send_byte(seed + 8'(i), i == n - 1);
        repeat (40) @(negedge clk);
    endtask

    task automatic check_buf(input string req, input logic [31:0] base,
                             input logic [7:0] first, input int n);
        int bad = 0;
        logic [7:0] got;
        for (int k = 0; k < n; k++) begin
            got = mem[(base + 32'(k)) >> 2][31 - 8*((base + 32'(k)) % 4) -: 8];
            if (got !== first + 8'(k)) bad++;
        end
        chk(req, 32'(bad), 32'd0);
    endtask

    task automatic settle();
        repeat (12) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_err++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        logic [31:0] rd;
        rst = 1'b1; ctrl_en = 1'b0; cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0;
        in_valid = 1'b0; in_data = '0; in_last = 1'b0;
        for (int i = 0; i < 1024; i++) mem[i] = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // reset state
        cfg_read(10'h010, rd); chk("R1 reset demand read", rd, 32'h0);
        cfg_read(10'h084, rd); chk("R9 reset control", rd, 32'h05EE_0001);
        cfg_read(10'h188, rd); chk("R4 reset buffer size", rd, 32'h600);
        chk("R2 ready low at reset", 32'(in_ready), 32'd0);

        // demand ignored while disabled
        setup_ring();
        cfg_write(10'h180, 32'h0);
        cfg_write(10'h010, 32'h0);
        settle();
        chk("R1 demand ignored when disabled", 32'(rx_armed), 32'd0);

        // arm
        cfg_write(10'h188, 32'h40);
        ctrl_en = 1'b1;
        cfg_write(10'h010, 32'h0);
        settle();
        cfg_read(10'h010, rd); chk("R1 armed bit 24", rd, 32'h0100_0000);
        chk("R1 ready when armed", 32'(in_ready), 32'd1);

        // single-buffer frame
        expect_wb(32'h00, 16'h0800, 16'd10); exp_f++;
        send_frame(10, 8'h11);
        check_buf("R4 data lanes frame 1", 32'h400, 8'h11, 10);
        chk("R10 stays armed next empty", 32'(rx_armed), 32'd1);

        // 150 bytes over 64-byte buffers, wrap then disarm
        expect_wb(32'h08, 16'h0000, 16'd64);
        expect_wb(32'h10, 16'h0000, 16'd64);
        expect_wb(32'h18, 16'h2800, 16'd22);
        exp_b += 2; exp_f++;
        send_frame(150, 8'h30);
        check_buf("R4 second buffer data", 32'h600, 8'h70, 64);
        check_buf("R4 third buffer data", 32'h700, 8'hB0, 22);
        chk("R10 disarm on full descriptor", 32'(rx_armed), 32'd0);
        chk("R2 ready low when disarmed", 32'(in_ready), 32'd0);
        chk("R6 buffer events", 32'(n_rxb), 32'(exp_b));
        chk("R6 frame events", 32'(n_rxf), 32'(exp_f));

        // exact multiple of buffer size
        setup_ring();
        cfg_write(10'h010, 32'h0);
        settle();
        expect_wb(32'h00, 16'h0000, 16'd64);
        expect_wb(32'h08, 16'h0800, 16'd64);
        exp_b++; exp_f++;
        send_frame(128, 8'h40);
        chk("R4 exact multiple stays armed", 32'(rx_armed), 32'd1);

        // length limit
        cfg_write(10'h084, 32'hFFFF_FFFF);
        cfg_read(10'h084, rd); chk("R9 control mask", rd, 32'h07FF_003F);
        cfg_write(10'h084, 32'h0010_0000);
        expect_wb(32'h10, 16'h0820, 16'd20); exp_f++;
        send_frame(20, 8'h01);
        expect_wb(32'h18, 16'h2800, 16'd16); exp_f++;
        send_frame(16, 8'h02);
        chk("R7 wrap lands on used descriptor", 32'(rx_armed), 32'd0);

        // truncation
        setup_ring();
        cfg_write(10'h084, 32'h07FF_0000);
        cfg_write(10'h188, 32'hFFFF_FFFF);
        cfg_read(10'h188, rd); chk("R4 buffer size mask", rd, 32'h7F0);
        cfg_write(10'h180, 32'h0000_0003);
        cfg_read(10'h180, rd); chk("R7 ring start low bits", rd, 32'h0);
        cfg_write(10'h010, 32'h0);
        settle();
        expect_wb(32'h00, 16'h0821, 16'd2032); exp_f++;
        send_frame(2040, 8'h07);
        check_buf("R8 truncated data", 32'h400, 8'h07, 2032);
        chk("R8 next descriptor armed", 32'(rx_armed), 32'd1);

        // zero buffer size acts as 16
        cfg_write(10'h188, 32'h0);
        cfg_read(10'h188, rd); chk("R4 zero size reads zero", rd, 32'h0);
        expect_wb(32'h08, 16'h0000, 16'd16);
        expect_wb(32'h10, 16'h0800, 16'd4);
        exp_b++; exp_f++;
        send_frame(20, 8'h90);
        check_buf("R4 tail after 16-byte split", 32'h600, 8'hA0, 4);

        // overrun: descriptor 0 still holds the truncated frame
        expect_wb(32'h18, 16'h2000, 16'd16); exp_b++;
        send_frame(40, 8'h20);
        chk("R11 overrun set", 32'(rx_overrun), 32'd1);
        chk("R11 disarmed after drop", 32'(rx_armed), 32'd0);
        chk("R11 full descriptor untouched", mem[0], 32'h0821_07F0);
        chk("R6 buffer events total", 32'(n_rxb), 32'(exp_b));
        chk("R6 frame events total", 32'(n_rxf), 32'(exp_f));

        // disable disarms
        mem[0] = 32'h8000_0000;
        cfg_write(10'h010, 32'h0);
        settle();
        chk("R1 rearm after refill", 32'(rx_armed), 32'd1);
        chk("R11 overrun still set", 32'(rx_overrun), 32'd1);
        ctrl_en = 1'b0;
        @(negedge clk);
        cfg_read(10'h010, rd); chk("R3 disable clears armed", rd, 32'h0);
        chk("R3 ready low after disable", 32'(in_ready), 32'd0);

        chk("R5 scoreboard drained", 32'(exp_q.size()), 32'd0);
        done = 1;
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end
endmodule